// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Idle-Line Detection and Standby

This block recovers asynchronous serial characters from a line that is sampled on a 16x oversampling clock enable. At run time it can take 8 or 9 data bits, with an optional parity bit that is checked as even or odd. Each finished character is reported with a one-cycle valid strobe. A parity error flag and a framing error flag travel with the character.

The line the receiver listens to is chosen at run time. It can be the dedicated receive pin, the internal transmitter output (loopback), or a transmit pin shared by both directions (single-wire). An idle-line detector reports a stretch of continuous high level that lasts one full character time. Its count starts either right after the start bit or only once the frame has been sampled.

A standby state suppresses character reporting. It is entered on request and left either on an idle line or on a character whose most significant data bit is set. That character is delivered. The baud-rate enable, the transmitter and any buffering sit outside the block.

Top module: `serial_rx_core`

## Requirements
- R1: With cfg_loop_en = 0 the receiver samples rx_pin. cfg_shared_wire has no effect in this case.
- R2: With cfg_loop_en = 1, rx_pin is ignored. The receiver samples tx_int when cfg_shared_wire = 0 and tx_pin when cfg_shared_wire = 1.
- R3: A low level is accepted as a start bit only if the line is still low at the 8th os_tick after the tick that first saw it low. Shorter low pulses produce no character.
- R4: Data bits are sampled every 16 os_ticks, least significant bit first. cfg_nine = 0 receives 8 bits and reports rx_data[8] = 0. cfg_nine = 1 receives 9 bits.
- R5: With cfg_par_en = 1, one parity bit follows the data bits and comes before the stop bit. cfg_par_odd = 0 requires an even count of ones over the data plus the parity bit, and 1 requires an odd count. A mismatch sets par_err. With cfg_par_en = 0, par_err is 0.
- R6: A low level at the stop-bit sample sets frm_err for that character.
- R7: Each delivered character raises rx_valid for exactly one cycle, with rx_data, par_err and frm_err valid in that cycle.
- R8: idle_line pulses for one cycle after F×16 consecutive high os_tick samples, where F = 1 + data bits + parity bit + 1 (10 to 12). Any low sample restarts the count.
- R9: With cfg_idle_after_stop = 0, high samples count from the end of the start bit. With cfg_idle_after_stop = 1, the count is held at zero while a frame is in progress and starts after the stop-bit sample.
- R10: After an idle_line pulse, no further pulse occurs until a new character has been received. Reset leaves the detector ready to report.
- R11: A sleep_req pulse clears awake. While awake = 0, received characters do not raise rx_valid unless R12 applies. If sleep_req falls in the same cycle as a wake event, standby wins.
- R12: With cfg_wake_addr = 1 in standby, a character whose top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 1 is delivered and sets awake. A character with that bit at 0 is dropped and leaves standby unchanged.
- R13: With cfg_wake_addr = 0 in standby, an idle_line pulse sets awake. With cfg_wake_addr = 1, idle_line does not wake the block.
- R14: After reset, rx_valid = 0, idle_line = 0 and awake = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_pin | input | 1 | Dedicated receive pin |
| tx_int | input | 1 | Internal transmitter output |
| tx_pin | input | 1 | Level on the shared transmit pin |
| cfg_loop_en | input | 1 | Take receiver input from the transmit side |
| cfg_shared_wire | input | 1 | With loop enabled: 0 internal loopback, 1 single-wire pin |
| cfg_nine | input | 1 | 0: 8 data bits, 1: 9 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_wake_addr | input | 1 | Standby exit: 0 idle line, 1 address-marked character |
| cfg_idle_after_stop | input | 1 | 0: idle count after start bit, 1: after stop bit |
| sleep_req | input | 1 | Enter standby |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Character delivered strobe |
| par_err | output | 1 | Parity error of the delivered character |
| frm_err | output | 1 | Framing error of the delivered character |
| idle_line | output | 1 | Idle line detected strobe |
| awake | output | 1 | 1 when not in standby |

## Verification
In address-mark standby, two functions fall in the same cycle: the wake decision and the delivery of the character that causes it. The bench puts the block to sleep and first sends a character whose top data bit is clear. That character must not appear, and awake must stay low. It then sends one with the top bit set, which must come out on rx_valid while awake rises right after. A behavioural model works out from the stimulus which characters must appear and in what order. Every clock is compared against it, so a character that is dropped when it should be delivered, or delivered when it should be dropped, shows up as a miscompare.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;

    typedef enum logic [1:0] {
        SRC_PIN,
        SRC_LOOP,
        SRC_WIRE
    } src_sel_e;

    typedef struct packed {
        logic       nine;
        logic       par_en;
        logic       par_odd;
    } frame_cfg_t;

    typedef struct packed {
        logic [8:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;

    // data bits plus optional parity bit
    function automatic logic [3:0] payload_bits(frame_cfg_t c);
        return 4'd8 + {3'b000, c.nine} + {3'b000, c.par_en};
    endfunction

    // whole frame: start + payload + stop
    function automatic logic [3:0] frame_bits(frame_cfg_t c);
        return payload_bits(c) + 4'd2;
    endfunction

    function automatic logic parity_fault(frame_cfg_t c, logic [8:0] d, logic pbit);
        logic [8:0] m;
        m = c.nine ? d : {1'b0, d[7:0]};
        return c.par_en & ((^m ^ pbit) != c.par_odd);
    endfunction

endpackage

// File: rtl/srx_src_mux.sv
module srx_src_mux
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_en,
    input  logic shared_wire,
    input  logic rx_pin,
    input  logic tx_int,
    input  logic tx_pin,
    output logic line
);

    src_sel_e sel;
    logic     raw;
    logic [SYNC_STAGES-1:0] sync_q;

    always_comb begin
        if (!loop_en)        sel = SRC_PIN;
        else if (shared_wire) sel = SRC_WIRE;
        else                 sel = SRC_LOOP;
    end

    always_comb begin
        unique case (sel)
            SRC_LOOP: raw = tx_int;
            SRC_WIRE: raw = tx_pin;
            default:  raw = rx_pin;
        endcase
    end

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign line = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  frame_cfg_t cfg,
    output logic       busy,
    output logic       done,
    output rx_char_t   chr
);

    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    fr_state_e   st;
    logic [CW-1:0] cnt;
    logic [3:0]  bidx;
    logic [9:0]  shreg;
    logic        done_q;
    rx_char_t    chr_q;

    logic [3:0]  nb;
    logic [9:0]  aligned;
    logic [8:0]  dword;
    logic        pbit;

    assign nb      = payload_bits(cfg);
    assign aligned = shreg >> (4'd10 - nb);
    assign dword   = cfg.nine ? aligned[8:0] : {1'b0, aligned[7:0]};
    assign pbit    = cfg.nine ? aligned[9] : aligned[8];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FR_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            done_q <= 1'b0;
            chr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                unique case (st)
                    FR_IDLE: begin
                        if (!line) begin
                            st  <= FR_START;
                            cnt <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt == CW'(MID - 1)) begin
                            cnt <= '0;
                            if (!line) begin
                                st   <= FR_DATA;
                                bidx <= '0;
                            end else begin
                                st <= FR_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[9:1]};
                            if (bidx == nb - 4'd1) st <= FR_STOP;
                            else                   bidx <= bidx + 4'd1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt        <= '0;
                            st         <= FR_IDLE;
                            done_q     <= 1'b1;
                            chr_q.data <= dword;
                            chr_q.perr <= parity_fault(cfg, dword, pbit);
                            chr_q.ferr <= !line;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= FR_IDLE;
                endcase
            end
        end
    end

    assign busy = (st != FR_IDLE);
    assign done = done_q;
    assign chr  = chr_q;

    // R3: entering the data phase requires a low mid-start sample
    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        (st == FR_DATA && $past(st) == FR_START) |-> !$past(line));

    // R4: bit index never runs past the configured payload
    assert_bit_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st == FR_DATA) |-> (bidx < nb));

    // R7: completion is a single-cycle event
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/srx_idle_det.sv
module srx_idle_det
    import srx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int MAX_FRAME = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic       busy,
    input  logic       after_stop,
    input  logic       char_done,
    input  frame_cfg_t cfg,
    output logic       idle_pulse
);

    localparam int IW = $clog2(MAX_FRAME * OVS + 1);

    logic [IW-1:0] cnt;
    logic [IW-1:0] thr;
    logic          armed;
    logic          pulse_q;

    assign thr = IW'(frame_bits(cfg) * OVS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            armed   <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick) begin
                if (!line || (after_stop && busy)) begin
                    cnt <= '0;
                end else if (cnt < thr) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == thr - IW'(1) && armed) begin
                        pulse_q <= 1'b1;
                        armed   <= 1'b0;
                    end
                end
            end
            if (char_done) armed <= 1'b1;
        end
    end

    assign idle_pulse = pulse_q;

    // R8: an idle report follows a high sample
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(line));

    // R9: stop-relative mode never reports while a frame was in progress
    assert_idle_type_R9: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && $past(after_stop)) |-> !$past(busy));

    // R10: no back-to-back reports
    assert_idle_once_R10: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/srx_wake_ctl.sv
module srx_wake_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_addr,
    input  logic char_done,
    input  logic char_msb,
    input  logic idle_pulse,
    output logic awake,
    output logic deliver
);

    logic awake_q;
    logic wake_evt;

    assign wake_evt = wake_addr ? (char_done && char_msb) : idle_pulse;
    assign deliver  = char_done && (awake_q || (wake_addr && char_msb));

    always_ff @(posedge clk) begin
        if (rst)            awake_q <= 1'b1;
        else if (sleep_req) awake_q <= 1'b0;
        else if (wake_evt)  awake_q <= 1'b1;
    end

    assign awake = awake_q;

    // R11: idle-wake standby delivers nothing
    assert_standby_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!awake_q && !wake_addr) |-> !deliver);

    // R12: address wake coincides with delivery of the waking character
    assert_addr_wake_R12: assert property (@(posedge clk) disable iff (rst)
        ($rose(awake_q) && $past(wake_addr)) |-> $past(deliver));

    // R13: idle wake follows an idle report
    assert_idle_wake_R13: assert property (@(posedge clk) disable iff (rst)
        ($rose(awake_q) && !$past(wake_addr)) |-> $past(idle_pulse));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx_pin,
    input  logic       tx_int,
    input  logic       tx_pin,
    input  logic       cfg_loop_en,
    input  logic       cfg_shared_wire,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_wake_addr,
    input  logic       cfg_idle_after_stop,
    input  logic       sleep_req,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       par_err,
    output logic       frm_err,
    output logic       idle_line,
    output logic       awake
);

    frame_cfg_t fcfg;
    logic       line;
    logic       busy;
    logic       done;
    rx_char_t   chr;
    logic       msb;
    logic       idle_pulse;
    logic       deliver;

    assign fcfg = {cfg_nine, cfg_par_en, cfg_par_odd};

    srx_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .clk         (clk),
        .rst         (rst),
        .loop_en     (cfg_loop_en),
        .shared_wire (cfg_shared_wire),
        .rx_pin      (rx_pin),
        .tx_int      (tx_int),
        .tx_pin      (tx_pin),
        .line        (line)
    );

    srx_framer #(.OVS(OVS)) u_framer (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .line (line),
        .cfg  (fcfg),
        .busy (busy),
        .done (done),
        .chr  (chr)
    );

    srx_idle_det #(.OVS(OVS)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .line       (line),
        .busy       (busy),
        .after_stop (cfg_idle_after_stop),
        .char_done  (done),
        .cfg        (fcfg),
        .idle_pulse (idle_pulse)
    );

    assign msb = cfg_nine ? chr.data[8] : chr.data[7];

    srx_wake_ctl u_wake (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .wake_addr  (cfg_wake_addr),
        .char_done  (done),
        .char_msb   (msb),
        .idle_pulse (idle_pulse),
        .awake      (awake),
        .deliver    (deliver)
    );

    assign rx_data   = chr.data;
    assign par_err   = chr.perr;
    assign frm_err   = chr.ferr;
    assign rx_valid  = deliver;
    assign idle_line = idle_pulse;

    // R7: one strobe per character
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: 8-bit mode never reports a ninth bit
    assert_eight_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_nine) |-> !rx_data[8]);

    // R5: parity flag stays clear without parity
    assert_no_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_par_en) |-> !par_err);

endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic rx_pin = 1'b1, tx_int = 1'b1, tx_pin = 1'b1;
    logic cfg_loop_en = 1'b0, cfg_shared_wire = 1'b0, cfg_nine = 1'b0;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wake_addr = 1'b0;
    logic cfg_idle_after_stop = 1'b0, sleep_req = 1'b0;
    logic [8:0] rx_data;
    logic rx_valid, par_err, frm_err, idle_line, awake;

    serial_rx_core uut (
        .clk(clk), .rst(rst), .os_tick(os_tick),
        .rx_pin(rx_pin), .tx_int(tx_int), .tx_pin(tx_pin),
        .cfg_loop_en(cfg_loop_en), .cfg_shared_wire(cfg_shared_wire),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_wake_addr(cfg_wake_addr), .cfg_idle_after_stop(cfg_idle_after_stop),
        .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
        .par_err(par_err), .frm_err(frm_err), .idle_line(idle_line), .awake(awake)
    );

    always #4 clk = ~clk;

    int vectors = 0, miscompares = 0, cyc = 0;
    int n_valid = 0, n_idle = 0, last_idle = 0;
    int n0, k, t_end, dly;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    logic [10:0] mon_e;
    string       mon_t;
    bit          m_awake = 1'b1;
    int          route = 0;
    logic        line_v = 1'b1, other_v = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_lines();
        rx_pin = (route == 0) ? line_v : other_v;
        tx_int = (route == 1) ? line_v : other_v;
        tx_pin = (route == 2) ? line_v : other_v;
    endtask

    task automatic drive_bit(input logic b);
        line_v = b;
        apply_lines();
        repeat (64) @(negedge clk);
    endtask

    task automatic gap(input int bits);
        line_v = 1'b1;
        apply_lines();
        repeat (64 * bits) @(negedge clk);
    endtask

    task automatic send_char(input logic [8:0] d, input bit bad_par,
                             input bit bad_stop, input string tag);
        logic [8:0] m;
        logic p;
        logic msb;
        m   = cfg_nine ? d : {1'b0, d[7:0]};
        p   = (^m) ^ cfg_par_odd;
        if (bad_par) p = ~p;
        msb = cfg_nine ? m[8] : m[7];
        if (!m_awake && cfg_wake_addr && msb) m_awake = 1'b1;
        if (m_awake) begin
            exp_q.push_back({m, cfg_par_en & bad_par, bad_stop});
            tag_q.push_back(tag);
        end
        drive_bit(1'b0);
        for (int i = 0; i < (cfg_nine ? 9 : 8); i++) drive_bit(m[i]);
        if (cfg_par_en) drive_bit(p);
        if (bad_stop) begin
            line_v = 1'b0; apply_lines();
            repeat (40) @(negedge clk);
            line_v = 1'b1; apply_lines();
            repeat (24) @(negedge clk);
        end else begin
            drive_bit(1'b1);
        end
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        m_awake = 1'b0;
        @(negedge clk);
    endtask

    task automatic switch_route(input int r);
        other_v = 1'b1; line_v = 1'b1; apply_lines();
        repeat (10) @(negedge clk);
        route = r; apply_lines();
        repeat (10) @(negedge clk);
        other_v = 1'b0; apply_lines();
        repeat (10) @(negedge clk);
    endtask

    // tick generation and per-clock comparison against the model
    initial forever begin
        @(negedge clk);
        cyc++;
        os_tick = (cyc % 4 == 0);
        if (!rst) begin
            if (rx_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk("R11 R7 unexpected character", {rx_data, par_err, frm_err}, -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(mon_t, {rx_data, par_err, frm_err}, mon_e);
                end
            end
            if (idle_line) begin
                n_idle++;
                last_idle = cyc;
            end
        end
    end

    initial begin
        repeat (190000) @(negedge clk);
        miscompares++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        apply_lines();
        repeat (5) @(negedge clk);
        chk("R14 reset rx_valid", rx_valid, 0);
        chk("R14 reset idle_line", idle_line, 0);
        chk("R14 reset awake", awake, 1);
        rst = 1'b0;
        repeat (1200) @(negedge clk);
        chk("R10 reset leaves idle armed", n_idle, 1);

        // R4: 8-bit characters
        send_char(9'h055, 0, 0, "R4 8-bit 0x55"); gap(2);
        send_char(9'h0A3, 0, 0, "R4 8-bit 0xA3"); gap(2);
        send_char(9'h000, 0, 0, "R4 8-bit 0x00"); gap(2);
        send_char(9'h1C3, 0, 0, "R4 ninth bit zero in 8-bit mode"); gap(2);
        // R4: 9-bit characters
        cfg_nine = 1'b1;
        send_char(9'h1A5, 0, 0, "R4 9-bit 0x1A5"); gap(2);
        send_char(9'h0FF, 0, 0, "R4 9-bit 0x0FF"); gap(2);
        // R5: parity
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_char(9'h1B3, 0, 0, "R5 even parity good"); gap(2);
        send_char(9'h1B3, 1, 0, "R5 even parity bad"); gap(2);
        cfg_nine = 1'b0; cfg_par_odd = 1'b1;
        send_char(9'h07E, 0, 0, "R5 odd parity good"); gap(2);
        send_char(9'h07E, 1, 0, "R5 odd parity bad"); gap(2);
        cfg_par_en = 1'b0;
        // R6: framing
        send_char(9'h03C, 0, 1, "R6 low stop sample"); gap(3);
        send_char(9'h0C8, 0, 0, "R6 recovery after framing error"); gap(3);
        // R3: short low pulse
        k = n_valid;
        line_v = 1'b0; apply_lines();
        repeat (16) @(negedge clk);
        gap(20);
        chk("R3 short low pulse ignored", n_valid - k, 0);

        // R8/R9: idle timing, start-relative
        cfg_idle_after_stop = 1'b0; gap(20);
        n0 = n_idle;
        send_char(9'h0FF, 0, 0, "R8 frame before idle"); t_end = cyc; gap(20);
        chk("R8 one idle report", n_idle - n0, 1);
        dly = last_idle - t_end;
        chk("R9 start-relative idle delay", int'(dly >= 40 && dly <= 110), 1);
        // stop-relative
        cfg_idle_after_stop = 1'b1; gap(5);
        n0 = n_idle;
        send_char(9'h0FF, 0, 0, "R9 frame before idle"); t_end = cyc; gap(20);
        chk("R9 stop-relative one report", n_idle - n0, 1);
        dly = last_idle - t_end;
        chk("R9 stop-relative idle delay", int'(dly >= 570 && dly <= 660), 1);
        // R10: no repeat without a new character
        n0 = n_idle; gap(30);
        chk("R10 no second idle report", n_idle - n0, 0);
        // R8: longer frame, longer threshold
        cfg_nine = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        n0 = n_idle;
        send_char(9'h1FF, 0, 0, "R8 12-bit frame"); t_end = cyc; gap(20);
        dly = last_idle - t_end;
        chk("R8 12-bit frame idle delay", int'(dly >= 700 && dly <= 790), 1);
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_idle_after_stop = 1'b0;

        // R11/R12: address-mark standby
        cfg_wake_addr = 1'b1; gap(3);
        go_sleep();
        chk("R11 sleep clears awake", awake, 0);
        k = n_valid;
        send_char(9'h041, 0, 0, "R11 dropped"); gap(2);
        chk("R11 character dropped in standby", n_valid - k, 0);
        chk("R12 clear top bit keeps standby", awake, 0);
        send_char(9'h0C1, 0, 0, "R12 address character delivered"); gap(1);
        chk("R12 address character wakes", awake, 1);
        send_char(9'h012, 0, 0, "R12 normal delivery after wake"); gap(2);
        // R13: idle does not wake in address mode
        go_sleep();
        gap(25);
        chk("R13 idle ignored in address mode", awake, 0);
        cfg_wake_addr = 1'b0;
        k = n_valid;
        send_char(9'h080, 0, 0, "R13 dropped"); gap(20);
        chk("R13 character dropped before idle", n_valid - k, 0);
        chk("R13 idle wakes", awake, 1);
        m_awake = 1'b1;

        // R1/R2: input routing
        cfg_loop_en = 1'b1; cfg_shared_wire = 1'b0;
        switch_route(1);
        send_char(9'h03C, 0, 0, "R2 internal loopback"); gap(2);
        cfg_shared_wire = 1'b1;
        switch_route(2);
        send_char(9'h0E7, 0, 0, "R2 single-wire pin"); gap(2);
        cfg_loop_en = 1'b0;
        switch_route(0);
        send_char(9'h05A, 0, 0, "R1 receive pin with wire bit set"); gap(2);
        cfg_shared_wire = 1'b0;
        other_v = 1'b1; apply_lines();
        gap(3);

        chk("R7 every expected character seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule